// File: doc/BRIEF.md
# Two-Slot Audio DMA Request Generator

This block drives the DMA request lines of a PCM audio interface that carries two slots (audio channels). Each slot has a receive data register, which reports when it is full, and a transmit data register, which reports when it is empty. Software picks which slots are served by DMA through a receive enable field and a transmit enable field. Separately, the interface reports which slots are assigned in each direction. A request for a slot goes out only when the slot's enable bit is set, the slot is assigned for that direction, and its register is in the state that needs service.

Each enable field is four bits wide. Only the two low bits stand for real slots. The two high bits are reserved and have no effect. All request outputs come from registers, so each one follows its inputs one clock later. A combined request, active when any single request is active, is registered in the same cycle as the per-slot lines. This lets a DMA controller with one request input use the block as well.

Top module: `audio_dma_req_gen`

## Requirements
- R1: rx_req[n] (n = 0 or 1) is 1 in the cycle after a rising clock edge at which rx_dma_en[n], rx_slot_assign[n] and rx_full[n] were all 1. Otherwise it is 0.
- R2: While rx_slot_assign[n] is 0, rx_req[n] stays 0 whatever rx_dma_en[n] and rx_full[n] are.
- R3: tx_req[n] is 1 in the cycle after a rising clock edge at which tx_dma_en[n], tx_slot_assign[n] and tx_empty[n] were all 1. Otherwise it is 0.
- R4: While tx_slot_assign[n] is 0, tx_req[n] stays 0 whatever tx_dma_en[n] and tx_empty[n] are.
- R5: Bits 3 and 2 of rx_dma_en and tx_dma_en affect no output.
- R6: any_req is 1 in exactly those cycles in which at least one bit of rx_req or tx_req is 1.
- R7: A rising clock edge with rst_n low clears rx_req, tx_req and any_req to 0, whatever the other inputs are.
- R8: rx_req[n] and tx_req[n] can be 1 at the same time when both their conditions hold.
- R9: A request drops one cycle after its status flag (rx_full or tx_empty) clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_dma_en | input | 4 | Receive DMA enable per slot; bits 3:2 reserved |
| tx_dma_en | input | 4 | Transmit DMA enable per slot; bits 3:2 reserved |
| rx_slot_assign | input | 2 | Slot assigned for receive |
| tx_slot_assign | input | 2 | Slot assigned for transmit |
| rx_full | input | 2 | Receive data register full, per slot |
| tx_empty | input | 2 | Transmit data register empty, per slot |
| rx_req | output | 2 | Receive DMA request, per slot |
| tx_req | output | 2 | Transmit DMA request, per slot |
| any_req | output | 1 | Any request active |

## Verification
The bench uses the default parameters: a four-bit enable field and two slots. With these values the inputs total sixteen bits, so every one of the 65,536 combinations is applied, one per cycle, in counting order. This covers every gating combination, including every pattern of the reserved bits. Because the low input bits change every cycle, it also covers every assert and release transition on each request line. Directed steps then check the reset clear, a slot that raises both directions at once, and the one-cycle release after a flag clears.

// File: rtl/audio_dma_pkg.sv
// Package: shared sizes and helpers for the audio DMA request generator.
// Assumes: the enable fields are at least as wide as the slot count.
package audio_dma_pkg;

    // Width of each software enable field (reserved bits included).
    parameter int unsigned EN_FIELD_W = 4;
    // Number of slots that exist in hardware.
    parameter int unsigned SLOT_COUNT = 2;

    // Per-direction selector used to document lane instances.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dma_dir_e;

    // Gate: the enable bit, the assignment bit and the status flag must all be set.
    function automatic logic slot_wants_service(input logic en_bit,
                                                input logic assigned,
                                                input logic flag);
        return en_bit & assigned & flag;
    endfunction

endpackage

// File: rtl/audio_dma_lane.sv
// Module: audio_dma_lane
// Builds the request lines for one direction (receive or transmit).
// For each slot it ANDs the enable bit, the assignment bit and the status
// flag, then registers the result. The unregistered result also goes out
// so the merge stage can register the combined request in the same cycle.
// Assumes: EN_W >= SLOTS. Enable bits at SLOTS and above are reserved and
// count for nothing.
module audio_dma_lane #(
    parameter int unsigned EN_W  = audio_dma_pkg::EN_FIELD_W,
    parameter int unsigned SLOTS = audio_dma_pkg::SLOT_COUNT,
    parameter audio_dma_pkg::dma_dir_e DIR = audio_dma_pkg::DIR_RX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EN_W-1:0]  en_field,
    input  logic [SLOTS-1:0] assigned,
    input  logic [SLOTS-1:0] flag,
    output logic [SLOTS-1:0] req_next,
    output logic [SLOTS-1:0] req
);

    localparam int unsigned RSVD_W = EN_W - SLOTS;

    logic [SLOTS-1:0] en_live;

    // Keep only the enable bits that stand for real slots.
    generate
        if (RSVD_W > 0) begin : g_rsvd
            logic rsvd_any;
            // Reserved bits are read here and given zero weight.
            assign rsvd_any = |en_field[EN_W-1:SLOTS];
            assign en_live  = en_field[SLOTS-1:0] | {SLOTS{rsvd_any & 1'b0}};
        end else begin : g_norsvd
            assign en_live = en_field[SLOTS-1:0];
        end
    endgenerate

    // One gate and one request register per slot.
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            // Combinational request condition for slot s.
            always_comb begin
                req_next[s] = audio_dma_pkg::slot_wants_service(en_live[s], assigned[s], flag[s]);
            end

            // Register the request; synchronous reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) req[s] <= 1'b0;
                else        req[s] <= req_next[s];
            end
        end
    endgenerate

endmodule

// File: rtl/audio_dma_merge.sv
// Module: audio_dma_merge
// Registers the OR of every next-cycle request of both directions. The
// combined line therefore lines up with the per-slot request registers.
// Assumes: the inputs are the unregistered conditions from the lanes.
module audio_dma_merge #(
    parameter int unsigned SLOTS = audio_dma_pkg::SLOT_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] rx_next,
    input  logic [SLOTS-1:0] tx_next,
    output logic             any_req
);

    logic any_next;

    // OR of all pending conditions.
    always_comb begin
        any_next = (|rx_next) | (|tx_next);
    end

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) any_req <= 1'b0;
        else        any_req <= any_next;
    end

endmodule

// File: rtl/audio_dma_req_gen.sv
// Module: audio_dma_req_gen (top)
// Makes the per-slot receive and transmit DMA requests and a combined
// request for a two-slot PCM audio interface. All outputs are registered.
// Assumes: the status flags and assignment bits are synchronous to clk.
module audio_dma_req_gen #(
    parameter int unsigned EN_W  = audio_dma_pkg::EN_FIELD_W,
    parameter int unsigned SLOTS = audio_dma_pkg::SLOT_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EN_W-1:0]  rx_dma_en,
    input  logic [EN_W-1:0]  tx_dma_en,
    input  logic [SLOTS-1:0] rx_slot_assign,
    input  logic [SLOTS-1:0] tx_slot_assign,
    input  logic [SLOTS-1:0] rx_full,
    input  logic [SLOTS-1:0] tx_empty,
    output logic [SLOTS-1:0] rx_req,
    output logic [SLOTS-1:0] tx_req,
    output logic             any_req
);

    logic [SLOTS-1:0] rx_next;
    logic [SLOTS-1:0] tx_next;

    // Receive lane: service is needed when the register is full.
    audio_dma_lane #(.EN_W(EN_W), .SLOTS(SLOTS), .DIR(audio_dma_pkg::DIR_RX)) u_rx_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_field (rx_dma_en),
        .assigned (rx_slot_assign),
        .flag     (rx_full),
        .req_next (rx_next),
        .req      (rx_req)
    );

    // Transmit lane: service is needed when the register is empty.
    audio_dma_lane #(.EN_W(EN_W), .SLOTS(SLOTS), .DIR(audio_dma_pkg::DIR_TX)) u_tx_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_field (tx_dma_en),
        .assigned (tx_slot_assign),
        .flag     (tx_empty),
        .req_next (tx_next),
        .req      (tx_req)
    );

    // Combined request.
    audio_dma_merge #(.SLOTS(SLOTS)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_next (rx_next),
        .tx_next (tx_next),
        .any_req (any_req)
    );

endmodule

// File: rtl/audio_dma_req_gen_chk.sv
// Module: audio_dma_req_gen_chk
// Watches the ports of audio_dma_req_gen and checks the request timing.
// Assumes: it is bound to the top, and slot 1 exists (SLOTS = 2).
module audio_dma_req_gen_chk #(
    parameter int unsigned EN_W  = 4,
    parameter int unsigned SLOTS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EN_W-1:0]  rx_dma_en,
    input logic [EN_W-1:0]  tx_dma_en,
    input logic [SLOTS-1:0] rx_slot_assign,
    input logic [SLOTS-1:0] tx_slot_assign,
    input logic [SLOTS-1:0] rx_full,
    input logic [SLOTS-1:0] tx_empty,
    input logic [SLOTS-1:0] rx_req,
    input logic [SLOTS-1:0] tx_req,
    input logic             any_req
);

    logic past_ok;

    // Goes high one cycle after reset is released, so that $past sees only post-reset values.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // R1: receive request slot 0 follows its gate one cycle later
    a_r1_rx_slot0: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rx_req[0] == $past(rx_dma_en[0] & rx_slot_assign[0] & rx_full[0]));

    // R1: receive request slot 1
    a_r1_rx_slot1: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rx_req[1] == $past(rx_dma_en[1] & rx_slot_assign[1] & rx_full[1]));

    // R2: an unassigned receive slot never requests
    a_r2_rx_unassigned: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(rx_slot_assign[0]) |-> !rx_req[0]);

    // R3: transmit request slot 0
    a_r3_tx_slot0: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        tx_req[0] == $past(tx_dma_en[0] & tx_slot_assign[0] & tx_empty[0]));

    // R3: transmit request slot 1
    a_r3_tx_slot1: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        tx_req[1] == $past(tx_dma_en[1] & tx_slot_assign[1] & tx_empty[1]));

    // R4: an unassigned transmit slot never requests
    a_r4_tx_unassigned: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(tx_slot_assign[1]) |-> !tx_req[1]);

    // R6: combined request agrees with the per-slot lines
    a_r6_any_match: assert property (@(posedge clk) disable iff (!rst_n)
        any_req == ((|rx_req) || (|tx_req)));

    // R7: reset clears every output on the next edge
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rx_req == '0 && tx_req == '0 && !any_req));

    // R9: request drops after the receive flag clears
    a_r9_rx_release: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $fell(rx_full[0]) |=> !rx_req[0]);

endmodule

bind audio_dma_req_gen audio_dma_req_gen_chk #(.EN_W(EN_W), .SLOTS(SLOTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_dma_en      (rx_dma_en),
    .tx_dma_en      (tx_dma_en),
    .rx_slot_assign (rx_slot_assign),
    .tx_slot_assign (tx_slot_assign),
    .rx_full        (rx_full),
    .tx_empty       (tx_empty),
    .rx_req         (rx_req),
    .tx_req         (tx_req),
    .any_req        (any_req)
);

// File: tb/audio_dma_req_gen_test.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of all 16 input bits, then directed steps.
module audio_dma_req_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_dma_en = '0;
    logic [3:0] tx_dma_en = '0;
    logic [1:0] rx_slot_assign = '0;
    logic [1:0] tx_slot_assign = '0;
    logic [1:0] rx_full = '0;
    logic [1:0] tx_empty = '0;
    logic [1:0] rx_req;
    logic [1:0] tx_req;
    logic       any_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    audio_dma_req_gen uut (
        .clk(clk), .rst_n(rst_n),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .rx_slot_assign(rx_slot_assign), .tx_slot_assign(tx_slot_assign),
        .rx_full(rx_full), .tx_empty(tx_empty),
        .rx_req(rx_req), .tx_req(tx_req), .any_req(any_req)
    );

    // Record one comparison.
    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, then sample just after the next rising edge.
    task automatic step(input logic [15:0] v);
        @(negedge clk);
        {rx_dma_en, tx_dma_en, rx_slot_assign, tx_slot_assign, rx_full, tx_empty} = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R7: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R7 reset", {rx_req | tx_req}, 2'b00);
        check("R7 reset any", {1'b0, any_req}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1..R6, R9: every input combination, expected values computed arithmetically
        for (int v = 0; v < 65536; v++) begin
            logic [1:0] erx, etx;
            logic [3:0] re, te;
            logic [1:0] ra, ta, rf, tm;
            step(v[15:0]);
            {re, te, ra, ta, rf, tm} = v[15:0];
            erx = re[1:0] & ra & rf;
            etx = te[1:0] & ta & tm;
            check((ra != 2'b11) ? "R1/R2/R5 rx" : "R1/R5 rx", rx_req, erx);
            check((ta != 2'b11) ? "R3/R4/R5 tx" : "R3/R5 tx", tx_req, etx);
            check("R6 any", {1'b0, any_req}, {1'b0, |{erx, etx}});
        end

        // R8: slot 0 requests in both directions at once
        step({4'b0001, 4'b0001, 2'b01, 2'b01, 2'b01, 2'b01});
        check("R8 both rx", rx_req, 2'b01);
        check("R8 both tx", tx_req, 2'b01);

        // R9: the full flag clears, and the request drops one cycle later
        step({4'b0011, 4'b0000, 2'b11, 2'b00, 2'b10, 2'b00});
        check("R9 release", rx_req, 2'b10);
        step({4'b0011, 4'b0000, 2'b11, 2'b00, 2'b00, 2'b00});
        check("R9 release", rx_req, 2'b00);

        // R5: only the reserved bits set, with every flag active
        step({4'b1100, 4'b1100, 2'b11, 2'b11, 2'b11, 2'b11});
        check("R5 reserved", rx_req | tx_req, 2'b00);

        // R7: a reset edge clears the outputs while every input is active
        step(16'hFFFF);
        check("R7 pre", rx_req & tx_req, 2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R7 clear", {rx_req | tx_req}, 2'b00);
        check("R7 clear any", {1'b0, any_req}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: an expired timer counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule